// File: doc/BRIEF.md
# Memory-Side Atomic Read-Modify-Write Engine

This block sits in front of one memory partition and carries out atomic read-modify-write requests on 32-bit words. A request names an operation, a word address, one or two operands and a requester tag. The block answers every request with the value the word held just before the update, together with the tag of the requester.

Words that are resident in the local store are updated in place in one cycle. Words that are not resident are read from backing memory, combined with the operands, and written back to backing memory. The miss path does not allocate the word into the local store. Only one miss is in flight at a time. A request to the address of that miss is held at the request port until the miss has delivered its response. Requests to the same word are therefore applied one after another, in the order they were accepted. A separate fill port installs words into the local store. All ports use valid/ready handshakes, except the read-data return, which the block always accepts.

Top module: `rmw_engine`

## Requirements
- R1: After reset the block offers no response, no backing read and no backing write. `req_ready` and `fill_ready` are high, and no word is resident, so the first request to any address is served from backing memory.
- R2: Operation code 0 (add) stores old + `req_opa` modulo 2^32 and returns the old value.
- R3: Operation code 1 (minimum) stores the smaller of the old value and `req_opa`. Operation code 2 (maximum) stores the larger. Both compare as signed 32-bit numbers and return the old value.
- R4: Operation code 3 (compare-and-swap) stores `req_opa` only when the old value equals `req_opb`. It returns the old value in both cases.
- R5: A request to a resident word updates that word in the local store and causes no backing read or write. Its response is offered in the cycle after the request is accepted.
- R6: A request to a non-resident word issues exactly one backing read of that address. Any result is written to the same address before the response is offered. The word does not become resident.
- R7: A compare-and-swap on a non-resident word whose comparison fails issues no backing write.
- R8: While a miss is in flight, `req_ready` stays low for a request to the same address until that miss's response has been accepted. Updates to that word are therefore never lost.
- R9: Each response carries the tag of the request it answers, and exactly one response is returned per accepted request.
- R10: On the response, backing-read and backing-write ports, an offered transfer keeps its valid high and its payload stable until it is accepted.
- R11: An accepted fill makes the word resident with the fill value. `fill_ready` is low when the fill address matches the in-flight miss. A fill takes precedence over a request to the same address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | Operation: 0 add, 1 min, 2 max, 3 compare-and-swap |
| req_addr | input | ADDR_W | Word address |
| req_opa | input | 32 | Operand, or swap value for compare-and-swap |
| req_opb | input | 32 | Compare value for compare-and-swap |
| req_tag | input | TAG_W | Requester identifier |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_old | output | 32 | Value held before the update |
| rsp_tag | output | TAG_W | Tag of the answered request |
| fill_valid | input | 1 | Fill offered |
| fill_ready | output | 1 | Fill accepted this cycle when valid |
| fill_addr | input | ADDR_W | Address to install |
| fill_data | input | 32 | Value to install |
| mem_rd_valid | output | 1 | Backing read offered |
| mem_rd_ready | input | 1 | Backing read taken |
| mem_rd_addr | output | ADDR_W | Backing read address |
| mem_rdata_valid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data |
| mem_wr_valid | output | 1 | Backing write offered |
| mem_wr_ready | input | 1 | Backing write taken |
| mem_wr_addr | output | ADDR_W | Backing write address |
| mem_wr_data | output | 32 | Backing write data |

## Verification
A wrong residency bit shows up at once on the backing ports: a read appears where none is due, or fails to appear, in the cycle after acceptance. A corrupted stored value does not show up on its own. It appears as a wrong `rsp_old` on the next atomic to that word, so the bench finishes by sweeping every address with an add of zero. A broken same-address hold loses an update, and that shows up later as a stale `rsp_old` or a wrong final backing word. A broken response arbiter shows up within one cycle as a changed payload while `rsp_valid` is held.

// File: rtl/rmw_pkg.sv
// Package rmw_pkg
// Shared word width and operation encoding for the atomic engine.
// Assumes every datapath word is WORD_W bits and compares are signed.
package rmw_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_MIN = 2'd1,
        OP_MAX = 2'd2,
        OP_CAS = 2'd3
    } rmw_op_e;
endpackage

// File: rtl/rmw_alu.sv
// Module rmw_alu
// Purely combinational update rule: from the old word and the operands it
// forms the new word, and says whether a store is needed at all.
// Assumes two's-complement operands; add wraps at the word width.
module rmw_alu #(
    parameter int W = rmw_pkg::WORD_W
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] new_val,
    output logic         wr_needed
);
    import rmw_pkg::*;

    logic a_less;
    logic a_more;
    logic cmp_eq;

    // Signed relations between the operand and the stored word.
    always_comb begin
        a_less = $signed(opa) < $signed(old_val);
        a_more = $signed(opa) > $signed(old_val);
        cmp_eq = (old_val == opb);
    end

    // Select the new word and whether it must be stored.
    always_comb begin
        new_val   = old_val;
        wr_needed = 1'b1;
        case (rmw_op_e'(op))
            OP_ADD: new_val = old_val + opa;
            OP_MIN: new_val = a_less ? opa : old_val;
            OP_MAX: new_val = a_more ? opa : old_val;
            OP_CAS: begin
                new_val   = cmp_eq ? opa : old_val;
                wr_needed = cmp_eq;
            end
            default: new_val = old_val;
        endcase
    end
endmodule

// File: rtl/rmw_store.sv
// Module rmw_store
// Local word store: one residency bit and one data word per address.
// Combinational read port, an update port for in-place atomics and a fill
// port that installs words. Assumes the two write ports never target the
// same address in one cycle and that updates only hit resident words.
module rmw_store #(
    parameter int ADDR_W = 6,
    parameter int W      = rmw_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [W-1:0]      rd_data,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [W-1:0]      upd_data,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [W-1:0]      fill_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] present_q;
    logic [W-1:0]     data_q [DEPTH];

    // Residency bits: cleared by reset, set by fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= '0;
        end else if (fill_en) begin
            present_q[fill_addr] <= 1'b1;
        end
    end

    // Data words: written by fills and by in-place atomic updates.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            data_q[fill_addr] <= fill_data;
        end
        if (upd_en) begin
            data_q[upd_addr] <= upd_data;
        end
    end

    // Read port for the request currently offered.
    always_comb begin
        rd_hit  = present_q[rd_addr];
        rd_data = data_q[rd_addr];
    end

    // R11: the engine must keep fills and updates on distinct words.
    assert_port_clash_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && upd_en && (fill_addr == upd_addr)));

    // R5: in-place updates only land on resident words.
    assert_upd_resident_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> present_q[upd_addr]);
endmodule

// File: rtl/rmw_miss_ctrl.sv
// Module rmw_miss_ctrl
// Single-slot miss sequencer: read the word from backing memory, apply the
// operation, write the result back when one is due, then offer the old
// value as a response. Assumes read data only returns while it waits for it.
module rmw_miss_ctrl #(
    parameter int ADDR_W = 6,
    parameter int TAG_W  = 4,
    parameter int W      = rmw_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        start_op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [W-1:0]      start_opa,
    input  logic [W-1:0]      start_opb,
    input  logic [TAG_W-1:0]  start_tag,
    output logic              busy,
    output logic [ADDR_W-1:0] busy_addr,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rdata_valid,
    input  logic [W-1:0]      mem_rdata,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [W-1:0]      mem_wr_data,
    output logic              rsp_valid,
    input  logic              rsp_take,
    output logic [W-1:0]      rsp_old,
    output logic [TAG_W-1:0]  rsp_tag
);
    typedef enum logic [2:0] {
        MS_IDLE,
        MS_READ,
        MS_WAIT,
        MS_WRITE,
        MS_RESP
    } miss_st_e;

    miss_st_e          st_q;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [W-1:0]      opa_q;
    logic [W-1:0]      opb_q;
    logic [TAG_W-1:0]  tag_q;
    logic [W-1:0]      old_q;
    logic [W-1:0]      new_q;
    logic [W-1:0]      calc_new;
    logic              calc_wr;

    rmw_alu #(.W(W)) u_alu (
        .op        (op_q),
        .old_val   (mem_rdata),
        .opa       (opa_q),
        .opb       (opb_q),
        .new_val   (calc_new),
        .wr_needed (calc_wr)
    );

    // Sequencer state: one miss from read through response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= MS_IDLE;
        end else begin
            case (st_q)
                MS_IDLE:  if (start)           st_q <= MS_READ;
                MS_READ:  if (mem_rd_ready)    st_q <= MS_WAIT;
                MS_WAIT:  if (mem_rdata_valid) st_q <= calc_wr ? MS_WRITE : MS_RESP;
                MS_WRITE: if (mem_wr_ready)    st_q <= MS_RESP;
                MS_RESP:  if (rsp_take)        st_q <= MS_IDLE;
                default:                       st_q <= MS_IDLE;
            endcase
        end
    end

    // Request capture when the slot is claimed.
    always_ff @(posedge clk) begin
        if (start && (st_q == MS_IDLE)) begin
            op_q   <= start_op;
            addr_q <= start_addr;
            opa_q  <= start_opa;
            opb_q  <= start_opb;
            tag_q  <= start_tag;
        end
    end

    // Old and new words captured when the read data returns.
    always_ff @(posedge clk) begin
        if ((st_q == MS_WAIT) && mem_rdata_valid) begin
            old_q <= mem_rdata;
            new_q <= calc_new;
        end
    end

    // Port drive derived from the sequencer state.
    always_comb begin
        busy         = (st_q != MS_IDLE);
        busy_addr    = addr_q;
        mem_rd_valid = (st_q == MS_READ);
        mem_rd_addr  = addr_q;
        mem_wr_valid = (st_q == MS_WRITE);
        mem_wr_addr  = addr_q;
        mem_wr_data  = new_q;
        rsp_valid    = (st_q == MS_RESP);
        rsp_old      = old_q;
        rsp_tag      = tag_q;
    end

    // R8: the engine starts a miss only into an empty slot.
    assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R10: an offered backing read holds until taken.
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R10: an offered backing write holds until taken.
    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R6: a backing write only ever follows returned read data.
    assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_valid) |-> $past(mem_rdata_valid));
endmodule

// File: rtl/rmw_engine.sv
// Module rmw_engine
// Atomic read-modify-write engine for one memory partition. Resident words
// are updated in place in one cycle; other words go through the single
// miss slot. A request to the in-flight miss address is held off, and a
// fill wins over a same-address request. Responses from the hit register
// and the miss slot share one port; an offered response is locked in place
// until taken. Assumes fills and requests come from one partition only.
module rmw_engine #(
    parameter int ADDR_W = 6,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_opa,
    input  logic [31:0]       req_opb,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_old,
    output logic [TAG_W-1:0]  rsp_tag,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [31:0]       fill_data,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rdata_valid,
    input  logic [31:0]       mem_rdata,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data
);
    localparam int W = rmw_pkg::WORD_W;

    logic              st_hit;
    logic [W-1:0]      st_data;
    logic [W-1:0]      hit_new;
    logic              hit_wr;
    logic              miss_busy;
    logic [ADDR_W-1:0] miss_addr;
    logic              mrsp_valid;
    logic [W-1:0]      mrsp_old;
    logic [TAG_W-1:0]  mrsp_tag;
    logic              mrsp_take;
    logic              hrsp_valid_q;
    logic [W-1:0]      hrsp_old_q;
    logic [TAG_W-1:0]  hrsp_tag_q;
    logic              hrsp_take;
    logic              lock_q;
    logic              lock_miss_q;
    logic              sel_miss;
    logic              addr_blocked;
    logic              fill_go;
    logic              fill_clash;
    logic              hit_room;
    logic              acc;
    logic              hit_acc;
    logic              miss_acc;

    rmw_store #(.ADDR_W(ADDR_W), .W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (req_addr),
        .rd_hit    (st_hit),
        .rd_data   (st_data),
        .upd_en    (hit_acc && hit_wr),
        .upd_addr  (req_addr),
        .upd_data  (hit_new),
        .fill_en   (fill_go),
        .fill_addr (fill_addr),
        .fill_data (fill_data)
    );

    rmw_alu #(.W(W)) u_hit_alu (
        .op        (req_op),
        .old_val   (st_data),
        .opa       (req_opa),
        .opb       (req_opb),
        .new_val   (hit_new),
        .wr_needed (hit_wr)
    );

    rmw_miss_ctrl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .W(W)) u_miss (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (miss_acc),
        .start_op        (req_op),
        .start_addr      (req_addr),
        .start_opa       (req_opa),
        .start_opb       (req_opb),
        .start_tag       (req_tag),
        .busy            (miss_busy),
        .busy_addr       (miss_addr),
        .mem_rd_valid    (mem_rd_valid),
        .mem_rd_ready    (mem_rd_ready),
        .mem_rd_addr     (mem_rd_addr),
        .mem_rdata_valid (mem_rdata_valid),
        .mem_rdata       (mem_rdata),
        .mem_wr_valid    (mem_wr_valid),
        .mem_wr_ready    (mem_wr_ready),
        .mem_wr_addr     (mem_wr_addr),
        .mem_wr_data     (mem_wr_data),
        .rsp_valid       (mrsp_valid),
        .rsp_take        (mrsp_take),
        .rsp_old         (mrsp_old),
        .rsp_tag         (mrsp_tag)
    );

    // Response source: keep a locked choice, otherwise favour the miss slot.
    always_comb begin
        sel_miss  = lock_q ? lock_miss_q : mrsp_valid;
        rsp_valid = sel_miss ? mrsp_valid : hrsp_valid_q;
        rsp_old   = sel_miss ? mrsp_old   : hrsp_old_q;
        rsp_tag   = sel_miss ? mrsp_tag   : hrsp_tag_q;
        mrsp_take = rsp_ready && sel_miss;
        hrsp_take = rsp_ready && !sel_miss && hrsp_valid_q;
    end

    // Admission: hazard hold, fill precedence and room on the chosen path.
    always_comb begin
        addr_blocked = miss_busy && (miss_addr == req_addr);
        fill_ready   = !(miss_busy && (miss_addr == fill_addr));
        fill_go      = fill_valid && fill_ready;
        fill_clash   = fill_go && (fill_addr == req_addr);
        hit_room     = !hrsp_valid_q || hrsp_take;
        req_ready    = !addr_blocked && !fill_clash && (st_hit ? hit_room : !miss_busy);
        acc          = req_valid && req_ready;
        hit_acc      = acc && st_hit;
        miss_acc     = acc && !st_hit;
    end

    // Hit response register: filled on a hit, emptied when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hrsp_valid_q <= 1'b0;
        end else if (hit_acc) begin
            hrsp_valid_q <= 1'b1;
        end else if (hrsp_take) begin
            hrsp_valid_q <= 1'b0;
        end
    end

    // Hit response payload captured at acceptance.
    always_ff @(posedge clk) begin
        if (hit_acc) begin
            hrsp_old_q <= st_data;
            hrsp_tag_q <= req_tag;
        end
    end

    // Arbitration lock: an offered but untaken response keeps its source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q      <= 1'b0;
            lock_miss_q <= 1'b0;
        end else begin
            lock_q      <= rsp_valid && !rsp_ready;
            lock_miss_q <= sel_miss;
        end
    end

    // R10: an offered response holds its payload until taken.
    assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_old) && $stable(rsp_tag)));

    // R8: nothing is admitted to the address of the in-flight miss.
    assert_hazard_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && miss_busy) |-> (req_addr != miss_addr));

    // R5: a hit produces a response in the following cycle.
    assert_hit_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && st_hit) |=> rsp_valid);

    // R11: a fill and a request to the same word are never admitted together.
    assert_fill_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_ready && req_valid && req_ready) |-> (fill_addr != req_addr));
endmodule

// File: tb/rmw_engine_test.sv
module rmw_engine_test;
    localparam int AW = 6;
    localparam int TW = 4;
    localparam int NW = 1 << AW;
    localparam int NT = 1 << TW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_opa = '0;
    logic [31:0]   req_opb = '0;
    logic [TW-1:0] req_tag = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [31:0]   rsp_old;
    logic [TW-1:0] rsp_tag;
    logic          fill_valid = 1'b0;
    logic          fill_ready;
    logic [AW-1:0] fill_addr = '0;
    logic [31:0]   fill_data = '0;
    logic          mem_rd_valid;
    logic          mem_rd_ready = 1'b0;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rdata_valid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          mem_wr_valid;
    logic          mem_wr_ready = 1'b0;
    logic [AW-1:0] mem_wr_addr;
    logic [31:0]   mem_wr_data;

    always #10 clk = ~clk;

    rmw_engine #(.ADDR_W(AW), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_old(rsp_old), .rsp_tag(rsp_tag),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
        .fill_data(fill_data),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0]   ref_val [NW];
    bit            ref_pres [NW];
    logic [31:0]   bmem [NW];
    logic [31:0]   exp_old [NT];
    logic [1:0]    exp_op [NT];
    bit            exp_pend [NT];
    logic [TW-1:0] next_tag = '0;
    int outstanding = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    bit mem_rand = 1'b0;
    bit rsp_rand = 1'b0;
    bit rsp_force = 1'b1;
    int rd_delay_fixed = 1;

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [31:0] f_new(input logic [1:0] op, input logic [31:0] old,
                                          input logic [31:0] a, input logic [31:0] b);
        case (op)
            2'd0:    return old + a;
            2'd1:    return ($signed(a) < $signed(old)) ? a : old;
            2'd2:    return ($signed(a) > $signed(old)) ? a : old;
            default: return (old == b) ? a : old;
        endcase
    endfunction

    function automatic string op_req(input logic [1:0] op);
        case (op)
            2'd0:    return "R2 add";
            2'd1:    return "R3 min";
            2'd2:    return "R3 max";
            default: return "R4 cas";
        endcase
    endfunction

    // Response monitor: drives rsp_ready, checks old values, tags and holds.
    initial begin
        bit            held = 1'b0;
        logic [TW-1:0] h_tag = '0;
        logic [31:0]   h_old = '0;
        forever begin
            @(negedge clk);
            rsp_ready = rsp_rand ? ($urandom % 4 != 0) : rsp_force;
            #1;
            if (held) begin
                check(rsp_valid && rsp_tag == h_tag && rsp_old == h_old,
                      "R10 rsp hold", rsp_old, h_old);
            end
            held  = rsp_valid && !rsp_ready;
            h_tag = rsp_tag;
            h_old = rsp_old;
            if (rsp_valid && rsp_ready) begin
                check(exp_pend[rsp_tag], "R9 tag", 32'(rsp_tag), 32'(rsp_tag));
                if (exp_pend[rsp_tag]) begin
                    check(rsp_old == exp_old[rsp_tag], op_req(exp_op[rsp_tag]),
                          rsp_old, exp_old[rsp_tag]);
                    exp_pend[rsp_tag] = 1'b0;
                    outstanding--;
                end
            end
        end
    end

    // Backing memory model with programmable or random latency.
    initial begin
        bit            pend = 1'b0;
        int            pend_cnt = 0;
        logic [AW-1:0] pend_addr = '0;
        logic [AW-1:0] last_rd = '0;
        bit            rd_held = 1'b0;
        logic [AW-1:0] rd_h_addr = '0;
        forever begin
            @(negedge clk);
            mem_rdata_valid = 1'b0;
            if (pend) begin
                if (pend_cnt == 0) begin
                    mem_rdata_valid = 1'b1;
                    mem_rdata       = bmem[pend_addr];
                    pend            = 1'b0;
                end else begin
                    pend_cnt--;
                end
            end
            mem_rd_ready = mem_rand ? ($urandom % 3 != 0) : 1'b1;
            mem_wr_ready = mem_rand ? ($urandom % 3 != 0) : 1'b1;
            #1;
            if (rd_held) begin
                check(mem_rd_valid && mem_rd_addr == rd_h_addr, "R10 read hold",
                      32'(mem_rd_addr), 32'(rd_h_addr));
            end
            rd_held   = mem_rd_valid && !mem_rd_ready;
            rd_h_addr = mem_rd_addr;
            if (mem_rd_valid && mem_rd_ready) begin
                rd_cnt++;
                pend      = 1'b1;
                pend_addr = mem_rd_addr;
                last_rd   = mem_rd_addr;
                pend_cnt  = mem_rand ? int'($urandom % 4) : rd_delay_fixed;
            end
            if (mem_wr_valid && mem_wr_ready) begin
                wr_cnt++;
                check(mem_wr_addr == last_rd, "R6 write address", 32'(mem_wr_addr),
                      32'(last_rd));
                bmem[mem_wr_addr] = mem_wr_data;
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic set_word(input int a, input logic [31:0] v);
        bmem[a]    = v;
        ref_val[a] = v;
    endtask

    // Drive one request starting now (just after a falling edge).
    task automatic issue(input logic [1:0] op, input int a, input logic [31:0] x,
                         input logic [31:0] y);
        logic [TW-1:0] tg;
        while (exp_pend[next_tag]) @(negedge clk);
        tg        = next_tag;
        next_tag  = next_tag + 1'b1;
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = AW'(a);
        req_opa   = x;
        req_opb   = y;
        req_tag   = tg;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        exp_old[tg]  = ref_val[a];
        exp_op[tg]   = op;
        exp_pend[tg] = 1'b1;
        outstanding++;
        ref_val[a] = f_new(op, ref_val[a], x, y);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fill_word(input int a, input logic [31:0] d);
        fill_valid = 1'b1;
        fill_addr  = AW'(a);
        fill_data  = d;
        forever begin
            #1;
            if (fill_ready) break;
            @(negedge clk);
        end
        ref_val[a]  = d;
        ref_pres[a] = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic drain();
        while (outstanding != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int rd0;
        int wr0;
        logic [31:0] keep;
        void'($urandom(32'd4242));
        for (int i = 0; i < NW; i++) begin
            bmem[i]     = $urandom;
            ref_val[i]  = bmem[i];
            ref_pres[i] = 1'b0;
        end
        for (int t = 0; t < NT; t++) exp_pend[t] = 1'b0;

        // R1: reset state at the ports
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(!rsp_valid, "R1 rsp_valid", 32'(rsp_valid), 0);
        check(!mem_rd_valid, "R1 mem_rd_valid", 32'(mem_rd_valid), 0);
        check(!mem_wr_valid, "R1 mem_wr_valid", 32'(mem_wr_valid), 0);
        check(req_ready, "R1 req_ready", 32'(req_ready), 1);
        check(fill_ready, "R1 fill_ready", 32'(fill_ready), 1);
        @(negedge clk);

        // R1/R2/R6: first access misses; add wraps past 2^32
        set_word(5, 32'hFFFF_FFF0);
        rd0 = rd_cnt; wr0 = wr_cnt;
        issue(2'd0, 5, 32'h20, 32'h0);
        drain();
        check(rd_cnt == rd0 + 1, "R1 no word resident (one read)", 32'(rd_cnt - rd0), 1);
        check(wr_cnt == wr0 + 1, "R6 one write", 32'(wr_cnt - wr0), 1);
        check(bmem[5] == 32'h10, "R2 wrapped sum in backing", bmem[5], 32'h10);
        issue(2'd0, 5, 32'h0, 32'h0);
        drain();
        check(rd_cnt == rd0 + 2, "R6 miss not allocated", 32'(rd_cnt - rd0), 2);

        // R5/R3: resident word, signed min/max, no backing traffic
        keep = bmem[9];
        fill_word(9, 32'd100);
        rd0 = rd_cnt; wr0 = wr_cnt;
        issue(2'd2, 9, 32'hFFFF_FFFB, 32'h0);
        #2;
        check(rsp_valid, "R5 response next cycle", 32'(rsp_valid), 1);
        @(negedge clk);
        issue(2'd1, 9, 32'hFFFF_FFFB, 32'h0);
        issue(2'd0, 9, 32'h0, 32'h0);
        issue(2'd2, 9, 32'h7FFF_FFFF, 32'h0);
        issue(2'd0, 9, 32'h0, 32'h0);
        drain();
        check(rd_cnt == rd0, "R5 no backing read", 32'(rd_cnt - rd0), 0);
        check(wr_cnt == wr0, "R5 no backing write", 32'(wr_cnt - wr0), 0);
        check(bmem[9] == keep, "R5 backing word untouched", bmem[9], keep);
        check(ref_val[9] == 32'h7FFF_FFFF, "R3 model max", ref_val[9], 32'h7FFF_FFFF);

        // R7/R4: compare-and-swap on a miss, failing then succeeding
        set_word(12, 32'd7);
        wr0 = wr_cnt;
        issue(2'd3, 12, 32'd99, 32'd8);
        drain();
        check(wr_cnt == wr0, "R7 failed swap writes nothing", 32'(wr_cnt - wr0), 0);
        check(bmem[12] == 32'd7, "R7 backing word kept", bmem[12], 32'd7);
        issue(2'd3, 12, 32'd99, 32'd7);
        drain();
        check(bmem[12] == 32'd99, "R4 swap stored", bmem[12], 32'd99);

        // R4/R11: compare-and-swap on a resident word
        fill_word(20, 32'd50);
        issue(2'd3, 20, 32'd1, 32'd51);
        issue(2'd0, 20, 32'h0, 32'h0);
        issue(2'd3, 20, 32'd1, 32'd50);
        issue(2'd0, 20, 32'h0, 32'h0);
        drain();

        // R8/R11: same-address hold behind an in-flight miss
        rd_delay_fixed = 6;
        keep = bmem[30];
        rd0  = rd_cnt;
        issue(2'd0, 30, 32'd1, 32'h0);
        req_valid = 1'b1; req_op = 2'd0; req_addr = AW'(30); req_opa = 32'd2;
        #1;
        check(!req_ready, "R8 same address held", 32'(req_ready), 0);
        req_addr = AW'(31);
        #1;
        check(!req_ready, "R8 second miss waits for slot", 32'(req_ready), 0);
        req_valid = 1'b0;
        fill_valid = 1'b1; fill_addr = AW'(30);
        #1;
        check(!fill_ready, "R11 fill blocked on miss address", 32'(fill_ready), 0);
        fill_addr = AW'(31);
        #1;
        check(fill_ready, "R11 fill elsewhere allowed", 32'(fill_ready), 1);
        fill_valid = 1'b0;
        issue(2'd0, 30, 32'd2, 32'h0);
        drain();
        check(bmem[30] == keep + 32'd3, "R8 no lost update", bmem[30], keep + 32'd3);
        check(rd_cnt == rd0 + 2, "R8 two serialized reads", 32'(rd_cnt - rd0), 2);
        rd_delay_fixed = 1;

        // R10: response held while not taken
        rsp_force = 1'b0;
        fill_word(40, 32'd1);
        issue(2'd0, 40, 32'd5, 32'h0);
        repeat (4) @(negedge clk);
        #2;
        check(rsp_valid, "R10 still offered", 32'(rsp_valid), 1);
        rsp_force = 1'b1;
        drain();

        // Random traffic on a small address window
        mem_rand = 1'b1;
        rsp_rand = 1'b1;
        for (int k = 0; k < 400; k++) begin
            int a;
            a = 32 + int'($urandom % 16);
            if ($urandom % 10 == 0) begin
                fill_word(a, $urandom);
            end else begin
                logic [1:0]  op;
                logic [31:0] x;
                logic [31:0] y;
                op = 2'($urandom % 4);
                x  = $urandom;
                y  = ($urandom % 2 == 0) ? ref_val[a] : $urandom;
                issue(op, a, x, y);
            end
        end
        drain();

        // Final sweep: every word read back through an add of zero
        for (int i = 0; i < NW; i++) issue(2'd0, i, 32'h0, 32'h0);
        drain();
        for (int i = 0; i < NW; i++) begin
            if (!ref_pres[i]) begin
                check(bmem[i] == ref_val[i], "R6 final backing word", bmem[i], ref_val[i]);
            end
        end

        summary();
        $finish;
    end
endmodule